// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a chain of boundary-scan cells placed between a chip's pads and its core. Each cell has a capture/shift flop, which is clocked on the rising test-clock edge, and an update latch, which is clocked on the falling edge. A multiplexer in each cell chooses between the functional path and the value held in the update latch. A TAP controller outside the block drives the capture, shift and update strobes and a two-bit mode code. The serial input and serial output of the chain connect to that controller's data-register selector.

Input cells sit on signals that travel from the pads to the core. Output cells sit on signals that travel from the core to the pads. In external-test mode the chain drives the pads and samples the pad inputs. In internal-test mode the chain drives the core and samples the core outputs. Sample/preload takes a snapshot of live traffic, or loads the update latches, without disturbing functional operation. An asynchronous test reset clears all storage and forces the functional path.

Top module: `bscan_chain`

## Requirements
- R1: When shift_en is high, each rising tck edge moves chain bit k to bit k+1 and loads scan_in into bit 0. Bits 0..N_IN-1 are the input cells and the bits above them are the output cells. scan_out takes the top chain bit on each falling tck edge, so a vector shifted in most-significant bit first also leaves most-significant bit first.
- R2: In external-test mode (mode 2'b10), a rising edge with capture_en high loads pin_in into the input cells and loads the value the output cells drive onto pin_out into the output cells.
- R3: In external-test mode, pin_out equals the output-cell update latches and core_in equals pin_in.
- R4: In internal-test mode (mode 2'b11), a rising edge with capture_en high loads core_out into the output cells and loads the input-cell update latches into the input cells.
- R5: In internal-test mode, core_in equals the input-cell update latches and pin_out equals core_out.
- R6: In sample/preload mode (mode 2'b01) and in functional mode (mode 2'b00), capture loads pin_in into the input cells and core_out into the output cells. In both modes, core_in follows pin_in and pin_out follows core_out during shift and update.
- R7: With update_en high, every update latch loads its chain bit on the falling tck edge in modes 2'b01, 2'b10 and 2'b11. In functional mode (2'b00) the update latches keep their values.
- R8: While trst_n is low, the chain, the update latches and scan_out are zero and both multiplexers select the functional path, whatever the mode. This takes effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_en | input | 1 | Capture strobe (capture-DR state) |
| shift_en | input | 1 | Shift strobe (shift-DR state) |
| update_en | input | 1 | Update strobe (update-DR state) |
| mode | input | 2 | 00 functional, 01 sample/preload, 10 external test, 11 internal test |
| scan_in | input | 1 | Serial data into chain bit 0 |
| scan_out | output | 1 | Serial data from the top chain bit, changes on falling tck |
| pin_in | input | N_IN | Levels arriving from input pads |
| core_in | output | N_IN | Values delivered to the core |
| core_out | input | N_OUT | Values produced by the core |
| pin_out | output | N_OUT | Values driven to output pads |

## Verification
The hardest case to reach is a test mode operating on update latches that hold a known, non-trivial vector. Before a capture can say anything about the latches, a full vector has to be preloaded under sample/preload and committed on a falling edge. The bench therefore preloads each table row serially, commits it, switches into the row's mode, captures, and shifts the captured image back out for comparison. It also uses directed sequences to show three more things: the drive change appears between the falling and the rising edge, an update in functional mode leaves the latches unchanged, and a reset with no clock edge restores the functional paths.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    typedef enum logic [1:0] {
        BS_FUNC   = 2'b00,
        BS_SAMPLE = 2'b01,
        BS_EXTEST = 2'b10,
        BS_INTEST = 2'b11
    } bs_mode_e;
endpackage

// File: rtl/bscan_capture_stage.sv
module bscan_capture_stage
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    localparam int LEN  = N_IN + N_OUT
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  bs_mode_e         mode,
    input  logic             scan_in,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_IN-1:0]  upd_in,
    input  logic [N_OUT-1:0] upd_out,
    output logic [LEN-1:0]   chain
);
    typedef struct packed {
        logic [LEN-1:0] chain;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic [LEN-1:0] cap_src;

    // Input cells observe the core side only during internal test.
    for (genvar i = 0; i < N_IN; i++) begin : g_in_src
        assign cap_src[i] = (mode == BS_INTEST) ? upd_in[i] : pin_in[i];
    end

    // Output cells observe their own pad drive during external test.
    for (genvar j = 0; j < N_OUT; j++) begin : g_out_src
        assign cap_src[N_IN+j] = (mode == BS_EXTEST) ? upd_out[j] : core_out[j];
    end

    always_comb begin
        st_d = st_q;
        if (capture_en) begin
            st_d.chain = cap_src;
        end else if (shift_en) begin
            st_d.chain = {st_q.chain[LEN-2:0], scan_in};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain = st_q.chain;
endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    localparam int LEN  = N_IN + N_OUT
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             update_en,
    input  bs_mode_e         mode,
    input  logic [LEN-1:0]   chain,
    output logic [N_IN-1:0]  upd_in,
    output logic [N_OUT-1:0] upd_out,
    output logic             scan_out
);
    typedef struct packed {
        logic [LEN-1:0] upd;
        logic           tdo;
    } upd_state_t;

    upd_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tdo = chain[LEN-1];
        if (update_en && (mode != BS_FUNC)) begin
            st_d.upd = chain;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_in   = st_q.upd[N_IN-1:0];
    assign upd_out  = st_q.upd[LEN-1:N_IN];
    assign scan_out = st_q.tdo;
endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             trst_n,
    input  bs_mode_e         mode,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_IN-1:0]  upd_in,
    input  logic [N_OUT-1:0] upd_out,
    output logic [N_IN-1:0]  core_in,
    output logic [N_OUT-1:0] pin_out
);
    logic drive_pads, drive_core;

    // Reset overrides the mode code and keeps both paths functional.
    assign drive_pads = trst_n && (mode == BS_EXTEST);
    assign drive_core = trst_n && (mode == BS_INTEST);

    for (genvar i = 0; i < N_IN; i++) begin : g_in_mux
        assign core_in[i] = drive_core ? upd_in[i] : pin_in[i];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out_mux
        assign pin_out[j] = drive_pads ? upd_out[j] : core_out[j];
    end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic [1:0]       mode,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out
);
    localparam int LEN = N_IN + N_OUT;

    bs_mode_e         mode_w;
    logic [LEN-1:0]   chain_w;
    logic [N_IN-1:0]  upd_in_w;
    logic [N_OUT-1:0] upd_out_w;

    assign mode_w = bs_mode_e'(mode);

    bscan_capture_stage #(.N_IN(N_IN), .N_OUT(N_OUT)) u_capture (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .mode       (mode_w),
        .scan_in    (scan_in),
        .pin_in     (pin_in),
        .core_out   (core_out),
        .upd_in     (upd_in_w),
        .upd_out    (upd_out_w),
        .chain      (chain_w)
    );

    bscan_update_stage #(.N_IN(N_IN), .N_OUT(N_OUT)) u_update (
        .tck       (tck),
        .trst_n    (trst_n),
        .update_en (update_en),
        .mode      (mode_w),
        .chain     (chain_w),
        .upd_in    (upd_in_w),
        .upd_out   (upd_out_w),
        .scan_out  (scan_out)
    );

    bscan_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
        .trst_n   (trst_n),
        .mode     (mode_w),
        .pin_in   (pin_in),
        .core_out (core_out),
        .upd_in   (upd_in_w),
        .upd_out  (upd_out_w),
        .core_in  (core_in),
        .pin_out  (pin_out)
    );
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    localparam int LEN  = N_IN + N_OUT
) (
    input logic             tck,
    input logic             trst_n,
    input logic             capture_en,
    input logic             shift_en,
    input logic             update_en,
    input logic [1:0]       mode,
    input logic             scan_in,
    input logic             scan_out,
    input logic [N_IN-1:0]  pin_in,
    input logic [N_OUT-1:0] core_out,
    input logic [LEN-1:0]   chain,
    input logic [LEN-1:0]   upd
);
    logic armed_p, armed_n;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) armed_p <= 1'b0;
        else         armed_p <= 1'b1;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) armed_n <= 1'b0;
        else         armed_n <= 1'b1;
    end

    assert_shift_move_R1: assert property (@(posedge tck) disable iff (!trst_n)
        armed_p && $past(shift_en && !capture_en)
        |-> (chain == {$past(chain[LEN-2:0]), $past(scan_in)}));

    assert_tdo_falling_R1: assert property (@(negedge tck) disable iff (!trst_n)
        armed_n |-> (scan_out == $past(chain[LEN-1])));

    assert_ext_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
        armed_p && $past(capture_en && (mode == 2'b10))
        |-> (chain[N_IN-1:0] == $past(pin_in)));

    assert_int_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        armed_p && $past(capture_en && (mode == 2'b11))
        |-> (chain[LEN-1:N_IN] == $past(core_out)));

    assert_func_hold_R7: assert property (@(negedge tck) disable iff (!trst_n)
        armed_n && $past(update_en && (mode == 2'b00))
        |-> (upd == $past(upd)));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .mode       (mode),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .pin_in     (pin_in),
    .core_out   (core_out),
    .chain      (chain_w),
    .upd        ({upd_out_w, upd_in_w})
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
    localparam int CLK_PERIOD = 20;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int NV = 5;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] load;
        logic [3:0] pin;
        logic [3:0] cout;
        logic [3:0] cin_x;
        logic [3:0] pout_x;
        logic [7:0] cap_x;
    } vec_t;

    // mode, preload, pin_in, core_out, expected core_in, pin_out, captured image
    localparam vec_t VECS [NV] = '{
        '{2'b10, 8'hA5, 4'h3, 4'hC, 4'h3, 4'hA, 8'hA3},
        '{2'b11, 8'h3C, 4'h9, 4'h6, 4'hC, 4'h6, 8'h6C},
        '{2'b01, 8'hF0, 4'h7, 4'h2, 4'h7, 4'h2, 8'h27},
        '{2'b00, 8'h81, 4'hE, 4'h1, 4'hE, 4'h1, 8'h1E},
        '{2'b10, 8'h5A, 4'h0, 4'hF, 4'h0, 4'h5, 8'h50}
    };

    logic          tck = 1'b0;
    logic          trst_n;
    logic          capture_en, shift_en, update_en;
    logic [1:0]    mode;
    logic          scan_in;
    logic          scan_out;
    logic [NI-1:0] pin_in;
    logic [NI-1:0] core_in;
    logic [NO-1:0] core_out;
    logic [NO-1:0] pin_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    logic last_so;

    bscan_chain #(.N_IN(NI), .N_OUT(NO)) uut (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .mode(mode), .scan_in(scan_in), .scan_out(scan_out),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Entered just after a rising edge; controls act at the next falling and rising edges.
    task automatic step(input logic cap, input logic sh, input logic up, input logic sin);
        capture_en = cap; shift_en = sh; update_en = up; scan_in = sin;
        @(negedge tck); #1;
        last_so = scan_out;
        @(posedge tck); #2;
        capture_en = 0; shift_en = 0; update_en = 0;
    endtask

    task automatic shift_vec(input logic [7:0] v, output logic [7:0] got);
        for (int j = 0; j < 8; j++) begin
            step(0, 1, 0, v[7-j]);
            got[7-j] = last_so;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        logic       so_prev;
        trst_n = 0; capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
        mode = 2'b10; pin_in = 4'h6; core_out = 4'h9;
        #3;
        check("R8 reset scan_out", scan_out, 0);
        check("R8 reset forces pin_out functional", pin_out, 4'h9);
        check("R8 reset forces core_in functional", core_in, 4'h6);
        @(posedge tck); #2;
        @(posedge tck); #2;
        trst_n = 1;
        #1;
        check("R8 latches cleared (extest pin_out)", pin_out, 4'h0);
        check("R3 extest core_in follows pin_in", core_in, 4'h6);
        shift_vec(8'h00, got);
        check("R8 chain cleared", got, 8'h00);

        // Table walk: preload, commit, enter mode, capture, unload.
        for (int k = 0; k < NV; k++) begin
            mode = 2'b01; pin_in = VECS[k].pin; core_out = VECS[k].cout;
            shift_vec(VECS[k].load, got);
            check("R6 sample keeps pin_out functional", pin_out, VECS[k].cout);
            step(0, 0, 1, 0);
            check("R6 sample keeps core_in functional", core_in, VECS[k].pin);
            mode = VECS[k].mode;
            step(0, 0, 0, 0);
            check("R3 R5 R6 core_in by mode", core_in, VECS[k].cin_x);
            check("R3 R5 R6 pin_out by mode", pin_out, VECS[k].pout_x);
            step(1, 0, 0, 0);
            shift_vec(8'h00, got);
            check("R1 R2 R4 R6 captured image", got, VECS[k].cap_x);
        end

        // R7: drive changes at the falling edge.
        pin_in = 4'h6; core_out = 4'h9; mode = 2'b01;
        shift_vec(8'hC3, got);
        mode = 2'b10;
        step(0, 0, 0, 0);
        check("R7 latches before update", pin_out, 4'h5);
        update_en = 1;
        @(negedge tck); #1;
        check("R7 pin_out changes at falling edge", pin_out, 4'hC);
        @(posedge tck); #2;
        update_en = 0;

        // R7: update in functional mode leaves latches alone.
        mode = 2'b01;
        shift_vec(8'h5F, got);
        mode = 2'b00;
        step(0, 0, 1, 0);
        mode = 2'b10;
        step(0, 0, 0, 0);
        check("R7 functional update ignored (pin side)", pin_out, 4'hC);
        mode = 2'b11;
        step(0, 0, 0, 0);
        check("R7 functional update ignored (core side)", core_in, 4'h3);

        // R1: scan_out moves only on the falling edge. Chain holds 5F here.
        mode = 2'b01;
        shift_en = 1; scan_in = 0;
        @(negedge tck); #1;
        so_prev = scan_out;
        check("R1 scan_out shows top bit", so_prev, 1'b0);
        @(posedge tck); #1;
        check("R1 scan_out steady at rising edge", scan_out, so_prev);
        shift_en = 0;
        @(negedge tck); #1;
        check("R1 scan_out updates at falling edge", scan_out, 1'b1);
        @(posedge tck); #2;

        // R8: asynchronous reset mid-test.
        mode = 2'b10;
        step(0, 0, 0, 0);
        check("R3 extest drives latch before reset", pin_out, 4'hC);
        #3;
        trst_n = 0;
        #1;
        check("R8 async reset restores pin_out", pin_out, 4'h9);
        check("R8 async reset clears scan_out", scan_out, 1'b0);
        @(posedge tck); #2;
        trst_n = 1;
        #1;
        check("R8 latches cleared after async reset", pin_out, 4'h0);
        finish_run();
    end
endmodule